// File: doc/BRIEF.md
# Lookup-Table Logic Neuron Network

This block is a feed-forward inference core in which every neuron is a small Boolean truth table rather than a weighted sum. A neuron picks `FAN_IN` bits from the layer before it and uses them as an address into a table of `2**FAN_IN` single-bit entries. The entry it addresses is the neuron's output. Layers are stacked with one register stage each. The wiring and the table contents are fixed when the design is elaborated. Both come from a deterministic hash of a seed, so a software model can rebuild the same network bit for bit.

The last layer's neurons are split into equal groups, one group per class. Each group is reduced to a count of set bits, and the class with the highest count wins. An input vector is presented with `valid_i`. The per-class counts and the winning class leave the block with `valid_o`. Input vectors can arrive on every cycle. Bubbles are allowed.

The hash is defined as follows. `xs(x)` applies `x ^= x<<13; x ^= x>>17; x ^= x<<5` on 32 bits. `mix(l,n,k) = xs(xs(SEED ^ l*32'h9E3779B9 ^ n*32'h85EBCA6B ^ k*32'hC2B2AE35 ^ 32'h6A09E667))`, where all products are taken modulo 2^32. `l` is the layer index from 0, `n` is the neuron index and `k` is a slot number.

Top module: `lgn_net`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first accepted vector emerges, `valid_o` is 0, every count is 0 and `class_o` is 0.
- R2: A neuron outputs the table entry whose index i has bit j equal to the neuron's j-th selected input.
- R3: The j-th selected input of neuron n in layer l is bit `mix(l,n,j) mod S` of its source. S is `IN_W` for layer 0 and `WIDTH` otherwise.
- R4: Table entry i of neuron n in layer l is bit 0 of `mix(l,n,8+i)`.
- R5: A vector accepted with `valid_i` high produces its result with `valid_o` high exactly `LAYERS` cycles later.
- R6: The count for class c equals the number of ones among last-layer neurons `c*G` to `c*G+G-1`, where `G = WIDTH/CLASSES`. That count sits in `counts_o[c*CNT_W +: CNT_W]`.
- R7: `class_o` is the index of the largest count. When counts tie, the lowest index wins.
- R8: Vectors presented on consecutive cycles each produce their own result on consecutive cycles.
- R9: A cycle with `valid_i` low yields `valid_o` low `LAYERS` cycles later. On that cycle the counts and class keep the values of the last accepted vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input vector is present |
| bits_i | input | IN_W | Flat input bit vector |
| valid_o | output | 1 | Result is present |
| counts_o | output | CLASSES*CNT_W | Per-class set-bit counts, class c at c*CNT_W |
| class_o | output | CLS_W | Winning class index |

## Verification
The assertions assume that `valid_i` is a clean 0 or 1 on every clock edge and that `rst_ni` is released only while `valid_i` is low. Given that, the valid pipeline can be checked one stage at a time. The stimulus stays inside these assumptions: it drives `valid_i` and `bits_i` only on the falling edge, and it holds `valid_i` low through reset. The stimulus sweeps all 2^16 input vectors of the default configuration back to back. A bubble falls on every seventh cycle, so forwarding, holding and ties on the argmax are all reached by inputs the bench legitimately drives.

// File: rtl/lgn_pkg.sv
package lgn_pkg;

  function automatic logic [31:0] lgn_xs(input logic [31:0] x);
    logic [31:0] y;
    y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  function automatic logic [31:0] lgn_mix(input logic [31:0] seed, input int unsigned layer,
                                          input int unsigned neuron, input int unsigned slot);
    logic [31:0] k;
    k = seed ^ (layer * 32'h9E3779B9) ^ (neuron * 32'h85EBCA6B)
        ^ (slot * 32'hC2B2AE35) ^ 32'h6A09E667;
    return lgn_xs(lgn_xs(k));
  endfunction

  function automatic int unsigned lgn_pick(input logic [31:0] seed, input int unsigned layer,
                                           input int unsigned neuron, input int unsigned j,
                                           input int unsigned src_w);
    return lgn_mix(seed, layer, neuron, j) % src_w;
  endfunction

  // up to six inputs -> at most 64 entries
  function automatic logic [63:0] lgn_table(input logic [31:0] seed, input int unsigned layer,
                                            input int unsigned neuron, input int unsigned fan_in);
    logic [63:0] t;
    logic [31:0] h;
    t = '0;
    for (int unsigned i = 0; i < 64; i++) begin
      if (i < (32'd1 << fan_in)) begin
        h = lgn_mix(seed, layer, neuron, 8 + i);
        t[i] = h[0];
      end
    end
    return t;
  endfunction

endpackage

// File: rtl/lgn_neuron.sv
module lgn_neuron #(
  parameter logic [31:0] SEED   = 32'h1F2E3D4C,
  parameter int unsigned LAYER  = 0,
  parameter int unsigned INDEX  = 0,
  parameter int unsigned SRC_W  = 16,
  parameter int unsigned FAN_IN = 4
) (
  input  logic [SRC_W-1:0] src_i,
  output logic             bit_o
);
  import lgn_pkg::*;

  localparam logic [63:0] TBL = lgn_table(SEED, LAYER, INDEX, FAN_IN);

  logic [FAN_IN-1:0] addr;
  logic              unused_src;

  for (genvar j = 0; j < FAN_IN; j++) begin : g_sel
    localparam int unsigned PICK = lgn_pick(SEED, LAYER, INDEX, j, SRC_W);
    assign addr[j] = src_i[PICK];
  end

  assign bit_o      = TBL[addr];
  assign unused_src = ^src_i;

endmodule

// File: rtl/lgn_layer.sv
module lgn_layer #(
  parameter logic [31:0] SEED   = 32'h1F2E3D4C,
  parameter int unsigned LAYER  = 0,
  parameter int unsigned SRC_W  = 16,
  parameter int unsigned DST_W  = 32,
  parameter int unsigned FAN_IN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [SRC_W-1:0] src_i,
  output logic             valid_o,
  output logic [DST_W-1:0] dst_o
);

  logic [DST_W-1:0] nxt;

  for (genvar n = 0; n < DST_W; n++) begin : g_neuron
    lgn_neuron #(
      .SEED  (SEED),
      .LAYER (LAYER),
      .INDEX (n),
      .SRC_W (SRC_W),
      .FAN_IN(FAN_IN)
    ) u_neuron (
      .src_i(src_i),
      .bit_o(nxt[n])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      dst_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) dst_o <= nxt;
    end
  end

  a_r5_valid_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r9_bubble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(dst_o));

endmodule

// File: rtl/lgn_readout.sv
module lgn_readout #(
  parameter int unsigned BITS_W  = 32,
  parameter int unsigned CLASSES = 4,
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned CLS_W   = 2
) (
  input  logic [BITS_W-1:0]        bits_i,
  output logic [CLASSES*CNT_W-1:0] counts_o,
  output logic [CLS_W-1:0]         class_o
);
  localparam int unsigned GROUP = BITS_W / CLASSES;

  logic [CNT_W-1:0] cnt [CLASSES];

  for (genvar c = 0; c < CLASSES; c++) begin : g_cls
    always_comb begin
      cnt[c] = '0;
      for (int b = 0; b < GROUP; b++) cnt[c] = cnt[c] + CNT_W'(bits_i[c*GROUP+b]);
    end
    assign counts_o[c*CNT_W +: CNT_W] = cnt[c];
  end

  // strict compare keeps the lowest index on ties
  always_comb begin
    logic [CNT_W-1:0] best;
    best    = cnt[0];
    class_o = '0;
    for (int c = 1; c < CLASSES; c++) begin
      if (cnt[c] > best) begin
        best    = cnt[c];
        class_o = CLS_W'(c);
      end
    end
  end

endmodule

// File: rtl/lgn_net.sv
module lgn_net #(
  parameter int unsigned IN_W    = 16,
  parameter int unsigned FAN_IN  = 4,   // 4..6
  parameter int unsigned LAYERS  = 2,
  parameter int unsigned WIDTH   = 32,
  parameter int unsigned CLASSES = 4,
  parameter logic [31:0] SEED    = 32'h1F2E3D4C,
  localparam int unsigned GROUP  = WIDTH / CLASSES,
  localparam int unsigned CNT_W  = $clog2(GROUP + 1),
  localparam int unsigned CLS_W  = (CLASSES > 1) ? $clog2(CLASSES) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [IN_W-1:0]          bits_i,
  output logic                     valid_o,
  output logic [CLASSES*CNT_W-1:0] counts_o,
  output logic [CLS_W-1:0]         class_o
);

  logic [WIDTH-1:0]  stage_d [LAYERS];
  logic [LAYERS-1:0] stage_v;

  for (genvar l = 0; l < LAYERS; l++) begin : g_layer
    if (l == 0) begin : g_first
      lgn_layer #(
        .SEED(SEED), .LAYER(0), .SRC_W(IN_W), .DST_W(WIDTH), .FAN_IN(FAN_IN)
      ) u_layer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .valid_i(valid_i),
        .src_i  (bits_i),
        .valid_o(stage_v[0]),
        .dst_o  (stage_d[0])
      );
    end else begin : g_next
      lgn_layer #(
        .SEED(SEED), .LAYER(l), .SRC_W(WIDTH), .DST_W(WIDTH), .FAN_IN(FAN_IN)
      ) u_layer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .valid_i(stage_v[l-1]),
        .src_i  (stage_d[l-1]),
        .valid_o(stage_v[l]),
        .dst_o  (stage_d[l])
      );
    end
  end

  lgn_readout #(
    .BITS_W(WIDTH), .CLASSES(CLASSES), .CNT_W(CNT_W), .CLS_W(CLS_W)
  ) u_readout (
    .bits_i  (stage_d[LAYERS-1]),
    .counts_o(counts_o),
    .class_o (class_o)
  );

  assign valid_o = stage_v[LAYERS-1];

  // cross-checks of the readout against its own outputs
  logic             cnt_ok, win_ok, tie_ok;
  logic [CNT_W-1:0] win_cnt;

  always_comb begin
    logic [CNT_W-1:0] v;
    win_cnt = counts_o[class_o*CNT_W +: CNT_W];
    cnt_ok  = 1'b1;
    win_ok  = 1'b1;
    tie_ok  = 1'b1;
    for (int c = 0; c < CLASSES; c++) begin
      v = counts_o[c*CNT_W +: CNT_W];
      if (v > CNT_W'(GROUP)) cnt_ok = 1'b0;
      if (v > win_cnt) win_ok = 1'b0;
      if ((CLS_W'(c) < class_o) && (v == win_cnt)) tie_ok = 1'b0;
    end
  end

  a_r6_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni) cnt_ok);
  a_r7_winner_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> win_ok);
  a_r7_tie_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> tie_ok);

endmodule

// File: tb/lgn_net_tb.sv
module lgn_net_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IN_W    = 16;
  localparam int FAN_IN  = 4;
  localparam int LAYERS  = 2;
  localparam int WIDTH   = 32;
  localparam int CLASSES = 4;
  localparam logic [31:0] SEED = 32'h1F2E3D4C;
  localparam int GROUP = WIDTH / CLASSES;
  localparam int CNT_W = $clog2(GROUP + 1);
  localparam int CLS_W = $clog2(CLASSES);

  logic                     clk = 1'b0;
  logic                     rst_ni = 1'b0;
  logic                     valid_i = 1'b0;
  logic [IN_W-1:0]          bits_i = '0;
  logic                     valid_o;
  logic [CLASSES*CNT_W-1:0] counts_o;
  logic [CLS_W-1:0]         class_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lgn_net #(
    .IN_W(IN_W), .FAN_IN(FAN_IN), .LAYERS(LAYERS), .WIDTH(WIDTH),
    .CLASSES(CLASSES), .SEED(SEED)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .bits_i(bits_i),
    .valid_o(valid_o), .counts_o(counts_o), .class_o(class_o)
  );

  // model network rebuilt from the hash in the requirements (R3, R4)
  int unsigned wsel [LAYERS][WIDTH][FAN_IN];
  logic [63:0] tbl  [LAYERS][WIDTH];

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  function automatic logic [31:0] mix(input int unsigned l, input int unsigned n, input int unsigned k);
    return xs(xs(SEED ^ (l * 32'h9E3779B9) ^ (n * 32'h85EBCA6B) ^ (k * 32'hC2B2AE35) ^ 32'h6A09E667));
  endfunction

  task automatic build_model();
    logic [31:0] h;
    for (int l = 0; l < LAYERS; l++)
      for (int n = 0; n < WIDTH; n++) begin
        for (int j = 0; j < FAN_IN; j++)
          wsel[l][n][j] = mix(l, n, j) % ((l == 0) ? IN_W : WIDTH);
        tbl[l][n] = '0;
        for (int i = 0; i < (1 << FAN_IN); i++) begin
          h = mix(l, n, 8 + i);
          tbl[l][n][i] = h[0];
        end
      end
  endtask

  // R2 addressing, R6 grouping, R7 lowest-index argmax
  task automatic model(input logic [IN_W-1:0] x, output logic [CLASSES*CNT_W-1:0] cnts,
                       output int cls, output bit tie);
    logic [63:0] src, dst;
    int addr, best, c;
    src = 64'(x);
    dst = '0;
    for (int l = 0; l < LAYERS; l++) begin
      dst = '0;
      for (int n = 0; n < WIDTH; n++) begin
        addr = 0;
        for (int j = 0; j < FAN_IN; j++) if (src[wsel[l][n][j]]) addr += (1 << j);
        dst[n] = tbl[l][n][addr];
      end
      src = dst;
    end
    cnts = '0;
    best = -1;
    cls = 0;
    tie = 0;
    for (int k = 0; k < CLASSES; k++) begin
      c = 0;
      for (int b = 0; b < GROUP; b++) c += int'(dst[k*GROUP+b]);
      cnts[k*CNT_W +: CNT_W] = CNT_W'(c);
      if (c > best) begin best = c; cls = k; tie = 0; end
      else if (c == best) tie = 1;
    end
  endtask

  logic [IN_W-1:0] hx [8];
  bit              hv [8];

  initial begin : main
    logic [CLASSES*CNT_W-1:0] ecnt, last_cnt;
    int ecls, last_cls, cyc, lat;
    bit tie, seen;
    build_model();
    repeat (3) @(negedge clk);
    // R1 reset state
    total++;
    if (valid_o !== 1'b0 || counts_o !== '0 || class_o !== '0) begin
      bad++;
      $display("FAIL R1 reset: valid=%0b counts=%h class=%0d exp 0/0/0", valid_o, counts_o, class_o);
    end
    rst_ni = 1'b1;
    @(negedge clk);
    total++;
    if (valid_o !== 1'b0 || counts_o !== '0) begin
      bad++;
      $display("FAIL R1 after release: valid=%0b counts=%h exp 0/0", valid_o, counts_o);
    end

    // exhaustive sweep, back to back (R8) with bubbles (R9)
    for (int k = 0; k < 8; k++) begin hv[k] = 0; hx[k] = '0; end
    cyc = 0;
    seen = 0;
    last_cnt = '0;
    last_cls = 0;
    for (int v = 0; v < (1 << IN_W) + 200; ) begin
      if (cyc >= LAYERS) begin
        int s;
        s = (cyc - LAYERS) & 7;
        total++;
        if (valid_o !== hv[s]) begin
          bad++;
          $display("FAIL R5 valid at cycle %0d: got %0b exp %0b", cyc, valid_o, hv[s]);
        end
        if (hv[s]) begin
          model(hx[s], ecnt, ecls, tie);
          total++;
          if (counts_o !== ecnt || int'(class_o) != ecls) begin
            bad++;
            $display("FAIL R2 R3 R4 R6 R7 R8 x=%h: counts=%h class=%0d exp counts=%h class=%0d%s",
                     hx[s], counts_o, class_o, ecnt, ecls, tie ? " (tie)" : "");
          end
          last_cnt = ecnt;
          last_cls = ecls;
          seen = 1;
        end else if (seen) begin
          total++;
          if (counts_o !== last_cnt || int'(class_o) != last_cls) begin
            bad++;
            $display("FAIL R9 hold: counts=%h class=%0d exp counts=%h class=%0d",
                     counts_o, class_o, last_cnt, last_cls);
          end
        end
      end
      if (v < (1 << IN_W) && (cyc % 7) != 3) begin
        valid_i = 1'b1;
        bits_i  = IN_W'(v);
        v++;
      end else begin
        valid_i = 1'b0;
        if (v >= (1 << IN_W)) v++;
      end
      hv[cyc & 7] = valid_i;
      hx[cyc & 7] = bits_i;
      cyc++;
      @(negedge clk);
    end

    // R5 single-pulse latency
    valid_i = 1'b0;
    repeat (6) @(negedge clk);
    valid_i = 1'b1;
    bits_i  = 16'hA5C3;
    @(negedge clk);
    valid_i = 1'b0;
    lat = 1;
    while (!valid_o && lat < 20) begin @(negedge clk); lat++; end
    total++;
    if (lat != LAYERS) begin
      bad++;
      $display("FAIL R5 latency: got %0d exp %0d", lat, LAYERS);
    end
    model(16'hA5C3, ecnt, ecls, tie);
    total++;
    if (counts_o !== ecnt || int'(class_o) != ecls) begin
      bad++;
      $display("FAIL R6 R7 pulse: counts=%h class=%0d exp counts=%h class=%0d",
               counts_o, class_o, ecnt, ecls);
    end
    @(negedge clk);
    total++;
    if (valid_o !== 1'b0) begin
      bad++;
      $display("FAIL R9 pulse end: valid=%0b exp 0", valid_o);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, got no end exp end");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule